// File: doc/BRIEF.md
# Serial Transmit Port Handshake Controller

This block sits between an external medium-access controller and the transmit modulator. The controller raises a packet enable to open a packet and drops it to close the packet. While the enable is active the block produces a bit clock divided down from the master clock and samples the serial data line once per bit-clock period, least significant bit first. The captured bits are packed into words and presented to the modulator on a valid/ready stream.

Two packet modes exist. In internal-preamble mode the block first counts out a programmed number of bit-clock periods that stand for the preamble and header. It raises a ready indication a programmed number of periods before it starts capturing data. In external-preamble mode the controller sends preamble and header itself, so the ready indication stays inactive and capture starts with the first bit-clock period. The capture edge and the active level of the enable, bit clock and ready pins are all configurable. Configuration inputs are expected to stay stable for the length of a packet. The mode is sampled when the packet starts.

Stream rules: a finished word is held on `word_data_o` with `word_valid_o` high until a cycle in which `word_ready_i` is high. The modulator is expected to take each word within the W bit periods that follow it. If it does not, the next finished word replaces the held one, so the newest word always wins.

Top module: `tx_serial_port`

## Requirements
- R1: Packet start is the first cycle in which the internal enable (the `tx_pe_i` pin XOR `cfg_inv_pe`) is seen high after being low. The internal bit clock starts low and toggles every `cfg_half` master cycles (a value of 0 behaves as 1). After the m-th clock edge following the start edge, its level is floor(m / H) mod 2.
- R2: When the internal enable goes low, the ready output goes inactive at once. The bit clock pin returns to its inactive level after the next clock edge. A partially assembled word is discarded, and the next packet starts packing from bit 0.
- R3: By default `txd_i` is sampled at each falling edge of the internal bit clock, in data phase only. The first bit sampled goes to bit 0 of a word, and each group of W bits forms one word.
- R4: With `cfg_cap_rise` = 1, sampling moves to the rising edges of the internal bit clock, starting with the first rising edge that follows entry to data phase.
- R5: In internal-preamble mode (`cfg_int_pre` = 1), data phase begins after P = `cfg_pre_syms` falling edges of the bit clock. Default-edge capture therefore takes its first bit at falling edge P+1.
- R6: In internal-preamble mode the internal ready signal is high once at least P − L falling edges have occurred (L = `cfg_rdy_lead`), or from the first cycle if L ≥ P. It then stays high until the enable drops.
- R7: In external-preamble mode (`cfg_int_pre` = 0) the internal ready signal stays low for the whole packet. Data phase starts at once, with the first capture on the first falling edge (or the first rising edge under R4).
- R8: `txclk_o` equals the internal bit clock XOR `cfg_inv_clk`. `tx_rdy_o` equals the internal ready XOR `cfg_inv_rdy`.
- R9: A finished word stays on `word_data_o` with `word_valid_o` high until accepted. A newer finished word overwrites an unaccepted one.
- R10: After reset the bit clock and ready are inactive, no packet is running and `word_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | HALF_W | Master cycles per half bit-clock period |
| cfg_int_pre | input | 1 | 1 = internal preamble mode, 0 = external |
| cfg_pre_syms | input | SYM_W | Preamble/header length in bit periods |
| cfg_rdy_lead | input | SYM_W | Ready lead time in bit periods |
| cfg_cap_rise | input | 1 | 1 = capture on rising bit-clock edge |
| cfg_inv_pe | input | 1 | Invert the packet-enable pin |
| cfg_inv_clk | input | 1 | Invert the bit-clock pin |
| cfg_inv_rdy | input | 1 | Invert the ready pin |
| tx_pe_i | input | 1 | Packet enable from the controller |
| txd_i | input | 1 | Serial transmit data |
| txclk_o | output | 1 | Bit clock to the controller |
| tx_rdy_o | output | 1 | Ready for data indication |
| word_valid_o | output | 1 | Captured word valid |
| word_data_o | output | WORD_W | Captured word, first bit in bit 0 |
| word_ready_i | input | 1 | Modulator accepts the word |

## Verification
The bench sweeps both modes, both capture edges, half periods 1 and 2, and every preamble length and lead time from 0 to 3. It checks the bit-clock and ready pin levels in every cycle, which separates off-by-one errors in the divider, the preamble count and the lead comparison. Each packet carries distinct byte values, so a wrong capture edge, a wrong first bit or a wrong bit order shows up as a wrong word. Separate packets hold back the ready input to show that a word is held and then overwritten, and end a packet after a partial word to show that the leftover bits are dropped.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } tsp_state_e;
endpackage

// File: rtl/tsp_clkgen.sv
module tsp_clkgen #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              lvl_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [HALF_W-1:0] hc;
  logic              lvl;
  logic              wrap;

  assign wrap   = run_i && (({1'b0, hc} + 1'b1) >= {1'b0, half_i});
  assign rise_o = wrap && !lvl;
  assign fall_o = wrap && lvl;
  assign lvl_o  = lvl;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      hc  <= '0;
      lvl <= 1'b0;
    end else if (wrap) begin
      hc  <= '0;
      lvl <= ~lvl;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!lvl && hc == '0));
endmodule

// File: rtl/tsp_seq.sv
module tsp_seq
  import tsp_pkg::*;
#(
  parameter int SYM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             int_pre_i,
  input  logic [SYM_W-1:0] pre_i,
  input  logic [SYM_W-1:0] lead_i,
  input  logic             cap_rise_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             run_o,
  output logic             cap_o,
  output logic             rdy_o
);
  tsp_state_e       state;
  logic             en_q;
  logic             mode_q;
  logic [SYM_W-1:0] sc;
  logic             start;
  logic             near_end;

  assign start    = en_i && !en_q;
  assign run_o    = en_i && (state != ST_IDLE);
  assign cap_o    = run_o && (state == ST_DATA) && (cap_rise_i ? rise_i : fall_i);
  assign near_end = ({1'b0, pre_i} - {1'b0, sc}) <= {1'b0, lead_i};
  assign rdy_o    = en_i && mode_q &&
                    ((state == ST_DATA) || ((state == ST_PRE) && near_end));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      state  <= ST_IDLE;
      mode_q <= 1'b0;
      sc     <= '0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        state <= ST_IDLE;
        sc    <= '0;
      end else if (start) begin
        mode_q <= int_pre_i;
        sc     <= '0;
        state  <= (int_pre_i && pre_i != '0) ? ST_PRE : ST_DATA;
      end else if (state == ST_PRE && fall_i) begin
        sc <= sc + 1'b1;
        if (({1'b0, sc} + 1'b1) == {1'b0, pre_i}) state <= ST_DATA;
      end
    end
  end

  assert_start_leaves_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state != ST_IDLE));
  assert_stop_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state == ST_IDLE && !rdy_o));
endmodule

// File: rtl/tsp_deser.sv
module tsp_deser #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              bit_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  input  logic              ready_i
);
  localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              done;

  assign done = cap_i && !clr_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt <= '0;
      sh  <= '0;
    end else if (cap_i) begin
      sh  <= {bit_i, sh[WORD_W-1:1]};
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (done) begin
      valid_o <= 1'b1;
      data_o  <= {bit_i, sh[WORD_W-1:1]};
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !done) |=> (valid_o && $stable(data_o)));
  assert_word_from_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(cap_i));
endmodule

// File: rtl/tx_serial_port.sv
module tx_serial_port #(
  parameter int WORD_W = 8,
  parameter int HALF_W = 8,
  parameter int SYM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic              cfg_int_pre,
  input  logic [SYM_W-1:0]  cfg_pre_syms,
  input  logic [SYM_W-1:0]  cfg_rdy_lead,
  input  logic              cfg_cap_rise,
  input  logic              cfg_inv_pe,
  input  logic              cfg_inv_clk,
  input  logic              cfg_inv_rdy,
  input  logic              tx_pe_i,
  input  logic              txd_i,
  output logic              txclk_o,
  output logic              tx_rdy_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  input  logic              word_ready_i
);
  logic en, run, cap, rdy, lvl, rise_ev, fall_ev;

  assign en       = tx_pe_i ^ cfg_inv_pe;
  assign txclk_o  = lvl ^ cfg_inv_clk;
  assign tx_rdy_o = rdy ^ cfg_inv_rdy;

  tsp_clkgen #(.HALF_W(HALF_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run_i(run), .half_i(cfg_half),
    .lvl_o(lvl), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  tsp_seq #(.SYM_W(SYM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .int_pre_i(cfg_int_pre),
    .pre_i(cfg_pre_syms), .lead_i(cfg_rdy_lead), .cap_rise_i(cfg_cap_rise),
    .rise_i(rise_ev), .fall_i(fall_ev), .run_o(run), .cap_o(cap), .rdy_o(rdy)
  );

  tsp_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .clr_i(!run), .cap_i(cap), .bit_i(txd_i),
    .valid_o(word_valid_o), .data_o(word_data_o), .ready_i(word_ready_i)
  );

  assert_ext_mode_no_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cfg_int_pre && $stable(cfg_int_pre) && $past(run)) |-> !rdy);
endmodule

// File: tb/sim_tx_serial_port.sv
module sim_tx_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_half = 8'd1;
  logic cfg_int_pre = 1'b0;
  logic [5:0] cfg_pre_syms = '0, cfg_rdy_lead = '0;
  logic cfg_cap_rise = 1'b0, cfg_inv_pe = 1'b0, cfg_inv_clk = 1'b0, cfg_inv_rdy = 1'b0;
  logic tx_pe_i = 1'b0, txd_i = 1'b0, word_ready_i = 1'b1;
  logic txclk_o, tx_rdy_o, word_valid_o;
  logic [7:0] word_data_o;

  int total = 0, bad = 0, cyc = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  tx_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_int_pre(cfg_int_pre),
    .cfg_pre_syms(cfg_pre_syms), .cfg_rdy_lead(cfg_rdy_lead), .cfg_cap_rise(cfg_cap_rise),
    .cfg_inv_pe(cfg_inv_pe), .cfg_inv_clk(cfg_inv_clk), .cfg_inv_rdy(cfg_inv_rdy),
    .tx_pe_i(tx_pe_i), .txd_i(txd_i), .txclk_o(txclk_o), .tx_rdy_o(tx_rdy_o),
    .word_valid_o(word_valid_o), .word_data_o(word_data_o), .word_ready_i(word_ready_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int byte_of(input int seed, input int j);
    return (seed * 13 + j * 71 + 5) & 255;
  endfunction

  task automatic run_pkt(input bit mode, input int p, input int l, input int h,
                         input bit rise, input int nbits, input int seed,
                         input bit hold, input bit ipe, input bit iclk, input bit irdy);
    int pe_eff, base, tot, words, nwords;
    @(negedge clk);
    cfg_int_pre = mode; cfg_pre_syms = 6'(p); cfg_rdy_lead = 6'(l);
    cfg_half = 8'(h); cfg_cap_rise = rise;
    cfg_inv_pe = ipe; cfg_inv_clk = iclk; cfg_inv_rdy = irdy;
    tx_pe_i = ipe; word_ready_i = !hold;
    @(negedge clk);
    chk(txclk_o == iclk, "R8 idle clk", int'(txclk_o), int'(iclk));
    chk(tx_rdy_o == irdy, "R8 idle rdy", int'(tx_rdy_o), int'(irdy));
    pe_eff = mode ? p : 0;
    base = rise ? (2 * pe_eff + 1) * h : 2 * (pe_eff + 1) * h;
    tot = base + 2 * h * (nbits - 1) + 6 * h;
    nwords = nbits / 8;
    words = 0;
    tx_pe_i = !ipe;
    for (int c = 1; c <= tot; c++) begin
      int m, lv, exr, idx;
      @(negedge clk);
      m = c - 1;
      lv = (m / h) % 2;
      chk(int'(txclk_o) == (lv ^ int'(iclk)), "R1/R8 clk level", int'(txclk_o), lv ^ int'(iclk));
      exr = (mode && ((m / (2 * h)) + l >= p)) ? 1 : 0;
      chk(int'(tx_rdy_o) == (exr ^ int'(irdy)), mode ? "R6 rdy" : "R7 rdy", int'(tx_rdy_o), exr ^ int'(irdy));
      if (word_valid_o && !hold) begin
        chk(words < nwords, "R5 word count", words, nwords);
        chk(int'(word_data_o) == byte_of(seed, words), rise ? "R4 word" : "R3 word",
            int'(word_data_o), byte_of(seed, words));
        words++;
      end
      idx = (c <= base) ? 0 : (c - base + 2 * h - 1) / (2 * h);
      txd_i = (idx < nbits) ? byte_of(seed, idx / 8) >> (idx % 8) : 1'b0;
    end
    tx_pe_i = ipe;
    @(negedge clk);
    chk(txclk_o == iclk, "R2 clk off", int'(txclk_o), int'(iclk));
    chk(tx_rdy_o == irdy, "R2 rdy off", int'(tx_rdy_o), int'(irdy));
    if (hold) begin
      chk(word_valid_o == 1'b1, "R9 held valid", int'(word_valid_o), 1);
      chk(int'(word_data_o) == byte_of(seed, nwords - 1), "R9 overwrite",
          int'(word_data_o), byte_of(seed, nwords - 1));
      word_ready_i = 1'b1;
      @(negedge clk);
      chk(word_valid_o == 1'b0, "R9 accept", int'(word_valid_o), 0);
    end else begin
      chk(words == nwords, "R2/R3 words", words, nwords);
      chk(word_valid_o == 1'b0, "R2 no partial word", int'(word_valid_o), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) cyc++;

  initial begin
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txclk_o == 1'b0, "R10 clk", int'(txclk_o), 0);
    chk(tx_rdy_o == 1'b0, "R10 rdy", int'(tx_rdy_o), 0);
    chk(word_valid_o == 1'b0, "R10 valid", int'(word_valid_o), 0);
    // R5 R6 R3 R4 R8: internal preamble sweep
    for (int r = 0; r < 2; r++)
      for (int h = 1; h <= 2; h++)
        for (int p = 0; p <= 3; p++)
          for (int l = 0; l <= 3; l++) begin
            run_pkt(1'b1, p, l, h, r[0], 16, seed, 1'b0, seed[0], seed[1], seed[2]);
            seed++;
          end
    // R7: external preamble, both edges, nonzero programmed preamble ignored
    for (int r = 0; r < 2; r++)
      for (int h = 1; h <= 3; h++) begin
        run_pkt(1'b0, 3, 1, h, r[0], 16, seed, 1'b0, seed[1], seed[0], seed[2]);
        seed++;
      end
    // R2: partial word dropped, next packet aligned from bit 0
    run_pkt(1'b1, 2, 1, 1, 1'b0, 11, seed, 1'b0, 1'b0, 1'b0, 1'b0);
    seed++;
    run_pkt(1'b0, 0, 0, 2, 1'b0, 8, seed, 1'b0, 1'b1, 1'b1, 1'b1);
    seed++;
    // R9: back-pressure, newest word kept
    run_pkt(1'b1, 1, 0, 1, 1'b0, 24, seed, 1'b1, 1'b0, 1'b0, 1'b0);
    seed++;
    run_pkt(1'b0, 0, 0, 2, 1'b1, 16, seed, 1'b1, 1'b0, 1'b1, 1'b0);
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule